// File: doc/BRIEF.md
# Edge Timestamping Counter Pair

The block timestamps rising edges of an external pulse after the fact. A free-running time-base counter advances once every `DIV` clocks. A second counter, the elapsed counter, advances at the same rate and is forced back to zero whenever the synchronized pulse input rises. A host that polls the block some time later takes one atomic snapshot of the tracked pulse level, the time-base count and the elapsed count. The difference between the time-base count and the elapsed count, taken modulo 2^16, is the time-base value at the moment of the edge. The result therefore does not depend on how long the host took to poll.

Each snapshot is compared with the level stored from the previous one. A low-to-high change raises a sticky event flag and latches the computed timestamp. A high-to-low change only updates the stored level. An echo output follows the stored level, with an optional inversion, so the pulse can be shown on an indicator. A small word-addressed register bus carries control, status, the snapshot values and the timestamp.

Top module: `edge_stamp_top`

## Requirements
- R1: After reset every register, both counters, the event flag and the echo output read 0.
- R2: The time-base count (live read at address 6) increments by one every `DIV` clocks and wraps from 0xFFFF to 0.
- R3: The pulse input passes through two synchronizer flops. When the synchronized level rises, the elapsed count (live read at address 7) restarts from 0. After that it advances on the same prescaler tick as the time base and wraps at 0xFFFF.
- R4: Writing any data to address 5 captures the tracked pulse level, the time-base count and the elapsed count in the same clock cycle. The time-base snapshot reads at address 2, the elapsed snapshot at address 3, and the level at status (address 1) bit 1.
- R5: On an event, the timestamp register (address 4) is loaded with the snapshot time-base value minus the snapshot elapsed value, modulo 2^16.
- R6: A snapshot raises the event flag (status bit 0) only when the captured level is 1 and the stored level (status bit 2) is 0. A captured level of 0 against a stored 1 updates the stored level and leaves the flag and the timestamp unchanged. An unchanged level changes nothing.
- R7: The event flag, also driven on `evt_o`, stays set until the host writes address 1 with data bit 0 at 1. A write with bit 0 at 0 leaves the flag unchanged.
- R8: The control register is at address 0, with bit 0 enabling the pulse input, bit 1 enabling the echo output and bit 2 inverting it. With echo disabled, `echo_o` is 0. With echo enabled, `echo_o` equals the stored level XOR the inversion bit.
- R9: With the pulse input disabled (control bit 0 at 0), snapshots still capture their values but never raise the flag, change the stored level or load the timestamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | External pulse, asynchronous |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| evt_o | output | 1 | Sticky assert-event flag |
| echo_o | output | 1 | Echo of the stored pulse level |

## Verification
Pulses are applied with several different spacings, and snapshots are taken at several offsets from each edge. Some snapshots land in the synchronizer window, before the edge is tracked, and others land well after it. The early ones show that the level, the time-base count and the elapsed count move together, and the late ones show that the timestamp stays fixed however late the poll comes. Repeated snapshots at a steady high level and snapshots at a falling level separate the true low-to-high event from a mere level change. Runs with the input disabled and with echo inversion set separate the gating paths from the event path. A long idle stretch drives both counters through their wrap.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_SNAPB = 3'd2,
    A_SNAPE = 3'd3,
    A_STAMP = 3'd4,
    A_SNAP  = 3'd5,
    A_LIVEB = 3'd6,
    A_LIVEE = 3'd7
  } reg_addr_e;

  typedef struct packed {
    logic echo_inv;
    logic echo_en;
    logic pulse_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/es_prescaler.sv
module es_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/es_sync_edge.sv
module es_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din_i};
      lvl_q  <= sync_q[STAGES-1];
    end
  end

  // level is aligned with the cycle the elapsed counter restarts
  assign level_o = lvl_q;
  assign rise_o  = sync_q[STAGES-1] & ~lvl_q;
endmodule

// File: rtl/es_counter.sv
module es_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/es_regs.sv
module es_regs
  import edge_stamp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              level_i,
  input  logic [W-1:0]      base_i,
  input  logic [W-1:0]      elap_i,
  output ctrl_t             ctrl_o,
  output logic              snap_o,
  output logic              evt_o,
  output logic              echo_o,
  output logic              lvl_snap_o,
  output logic              state_o,
  output logic [W-1:0]      stamp_o,
  output logic [W-1:0]      sbase_o,
  output logic [W-1:0]      selap_o
);
  ctrl_t        ctrl_q;
  logic         evt_q, state_q, lvl_q, echo_q;
  logic [W-1:0] stamp_q, sbase_q, selap_q;
  logic         snap_req, clr_req, ctrl_we, changed;

  assign snap_req = wr_i && (addr_i == A_SNAP);
  assign clr_req  = wr_i && (addr_i == A_STAT) && wdata_i[0];
  assign ctrl_we  = wr_i && (addr_i == A_CTRL);
  assign changed  = snap_req && ctrl_q.pulse_en && (level_i != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      sbase_q <= '0;
      selap_q <= '0;
    end else if (snap_req) begin
      lvl_q   <= level_i;
      sbase_q <= base_i;
      selap_q <= elap_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      echo_q  <= 1'b0;
      stamp_q <= '0;
    end else if (changed) begin
      state_q <= level_i;
      echo_q  <= level_i;
      if (level_i) stamp_q <= base_i - elap_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 evt_q <= 1'b0;
    else if (changed && level_i) evt_q <= 1'b1;
    else if (clr_req)            evt_q <= 1'b0;
  end

  assign ctrl_o     = ctrl_q;
  assign snap_o     = snap_req;
  assign evt_o      = evt_q;
  assign echo_o     = ctrl_q.echo_en & (echo_q ^ ctrl_q.echo_inv);
  assign lvl_snap_o = lvl_q;
  assign state_o    = state_q;
  assign stamp_o    = stamp_q;
  assign sbase_o    = sbase_q;
  assign selap_o    = selap_q;
endmodule

// File: rtl/edge_stamp_top.sv
module edge_stamp_top
  import edge_stamp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              evt_o,
  output logic              echo_o
);
  logic             tick, level, rise, snap_req, lvl_snap, state;
  logic [CNT_W-1:0] base_cnt, elap_cnt, stamp, sbase, selap;
  ctrl_t            ctrl;

  es_prescaler #(.DIV(DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  es_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(pulse_i),
    .level_o(level), .rise_o(rise)
  );

  es_counter #(.W(CNT_W)) u_base (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(1'b0), .inc_i(tick), .cnt_o(base_cnt)
  );

  es_counter #(.W(CNT_W)) u_elap (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rise), .inc_i(tick), .cnt_o(elap_cnt)
  );

  es_regs #(.W(CNT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .level_i(level), .base_i(base_cnt), .elap_i(elap_cnt),
    .ctrl_o(ctrl), .snap_o(snap_req), .evt_o(evt_o), .echo_o(echo_o),
    .lvl_snap_o(lvl_snap), .state_o(state), .stamp_o(stamp),
    .sbase_o(sbase), .selap_o(selap)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:  rdata_o = CNT_W'(ctrl);
      A_STAT:  rdata_o = CNT_W'({state, lvl_snap, evt_o});
      A_SNAPB: rdata_o = sbase;
      A_SNAPE: rdata_o = selap;
      A_STAMP: rdata_o = stamp;
      A_LIVEB: rdata_o = base_cnt;
      A_LIVEE: rdata_o = elap_cnt;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/edge_stamp_chk.sv
module edge_stamp_chk
  import edge_stamp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick,
  input logic              rise,
  input logic              snap_req,
  input ctrl_t             ctrl,
  input logic [CNT_W-1:0]  base_cnt,
  input logic [CNT_W-1:0]  elap_cnt,
  input logic [CNT_W-1:0]  stamp,
  input logic [CNT_W-1:0]  sbase,
  input logic [CNT_W-1:0]  selap,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic              evt_o,
  input logic              echo_o
);
  p_base_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(base_cnt) |-> base_cnt == $past(base_cnt) + 1'b1);

  p_base_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !$stable(base_cnt));

  p_elap_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> elap_cnt == '0);

  p_evt_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> $past(snap_req && ctrl.pulse_en));

  p_stamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> stamp == sbase - selap);

  p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(evt_o) |-> $past(wr_i && addr_i == A_STAT && wdata_i[0]));

  p_echo_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(evt_o) && ctrl.echo_en && !ctrl.echo_inv) |-> echo_o);

  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl.pulse_en |=> !$rose(evt_o));
endmodule

bind edge_stamp_top edge_stamp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .rise(rise), .snap_req(snap_req),
  .ctrl(ctrl), .base_cnt(base_cnt), .elap_cnt(elap_cnt), .stamp(stamp),
  .sbase(sbase), .selap(selap), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .evt_o(evt_o), .echo_o(echo_o)
);

// File: tb/sim_edge_stamp_top.sv
`timescale 1ns/1ps
module sim_edge_stamp_top;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pulse = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        evt, echo;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  edge_stamp_top #(.CNT_W(16), .DIV(DIV), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_o(evt), .echo_o(echo)
  );

  // behavioural reference
  int          m_pre;
  logic [15:0] m_base, m_elap, m_sb, m_se, m_stamp;
  bit          m_s1, m_s2, m_s3, m_state, m_lvl, m_evt, m_echo;
  bit   [2:0]  m_ctrl;

  always @(posedge clk or negedge rst_n) begin : model
    bit tk, rs, lv;
    logic [15:0] b, e;
    if (!rst_n) begin
      m_pre = 0; m_base = 0; m_elap = 0; m_sb = 0; m_se = 0; m_stamp = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_state = 0; m_lvl = 0; m_evt = 0;
      m_echo = 0; m_ctrl = 0;
    end else begin
      tk = (m_pre == DIV - 1);
      rs = m_s2 && !m_s3;
      lv = m_s3;
      b  = m_base;
      e  = m_elap;
      m_pre  = tk ? 0 : m_pre + 1;
      if (tk) m_base = b + 16'd1;
      if (rs) m_elap = 16'd0;
      else if (tk) m_elap = e + 16'd1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pulse;
      if (wr && addr == 3'd1 && wdata[0]) m_evt = 0;
      if (wr && addr == 3'd5) begin
        m_lvl = lv; m_sb = b; m_se = e;
        if (m_ctrl[0] && lv != m_state) begin
          m_state = lv;
          m_echo  = lv;
          if (lv) begin
            m_evt = 1;
            m_stamp = b - e;
          end
        end
      end
      if (wr && addr == 3'd0) m_ctrl = wdata[2:0];
    end
  end

  function automatic logic [15:0] m_rdata(input logic [2:0] a);
    case (a)
      3'd0: return {13'd0, m_ctrl};
      3'd1: return {13'd0, m_state, m_lvl, m_evt};
      3'd2: return m_sb;
      3'd3: return m_se;
      3'd4: return m_stamp;
      3'd6: return m_base;
      3'd7: return m_elap;
      default: return 16'd0;
    endcase
  endfunction

  function automatic string addr_tag(input logic [2:0] a);
    case (a)
      3'd0: return "R8";
      3'd1: return "R6";
      3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      3'd6: return "R2";
      3'd7: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check("R7", {15'd0, evt}, {15'd0, m_evt});
      check("R8", {15'd0, echo}, {15'd0, m_ctrl[1] & (m_echo ^ m_ctrl[2])});
      check(addr_tag(addr), rdata, m_rdata(addr));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 16'd0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a;
    #2 v = rdata;
  endtask

  logic [15:0] v, sb, se, st;

  initial begin
    idle(3);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1 check("R1", rdata, 16'd0);
    end
    check("R1", {14'd0, evt, echo}, 16'd0);
    #10 rst_n = 1'b1;

    wr_reg(3'd0, 16'h0003);          // pulse + echo on (R8)
    idle(40);
    @(negedge clk) pulse = 1'b1;
    idle(25);
    wr_reg(3'd5, 16'd0);              // snapshot -> event
    check("R7", {15'd0, evt}, 16'd1);
    check("R8", {15'd0, echo}, 16'd1);
    rd_reg(3'd1, v);  check("R4", v & 16'h2, 16'h2);
    rd_reg(3'd2, sb); rd_reg(3'd3, se); rd_reg(3'd4, st);
    check("R5", st, sb - se);
    idle(100);
    wr_reg(3'd5, 16'd0);              // late poll: same stamp
    rd_reg(3'd4, v);  check("R5", v, st);

    wr_reg(3'd1, 16'h0000);           // write 0: flag kept
    check("R7", {15'd0, evt}, 16'd1);
    wr_reg(3'd1, 16'h0001);
    check("R7", {15'd0, evt}, 16'd0);
    wr_reg(3'd5, 16'd0);              // still high: no event
    check("R6", {15'd0, evt}, 16'd0);

    @(negedge clk) pulse = 1'b0;
    idle(10);
    wr_reg(3'd5, 16'd0);              // falling: state only
    check("R6", {15'd0, evt}, 16'd0);
    rd_reg(3'd4, v);  check("R6", v, st);
    check("R8", {15'd0, echo}, 16'd0);
    wr_reg(3'd0, 16'h0007);           // inverted echo
    check("R8", {15'd0, echo}, 16'd1);
    wr_reg(3'd0, 16'h0001);           // echo off
    check("R8", {15'd0, echo}, 16'd0);

    wr_reg(3'd0, 16'h0000);           // input disabled
    @(negedge clk) pulse = 1'b1;
    idle(12);
    wr_reg(3'd5, 16'd0);
    check("R9", {15'd0, evt}, 16'd0);
    rd_reg(3'd1, v);  check("R9", v & 16'h4, 16'h0);
    rd_reg(3'd4, v);  check("R9", v, st);
    @(negedge clk) pulse = 1'b0;

    // elapsed restart and wrap of both counters
    idle(20);
    @(negedge clk) pulse = 1'b1;
    idle(10);
    rd_reg(3'd7, v);  check("R3", {15'd0, v <= 16'd6}, 16'd1);
    @(negedge clk) pulse = 1'b0;
    idle(65536 * DIV + 50);
    rd_reg(3'd6, v);  check("R2", {15'd0, v < 16'd600}, 16'd1);
    rd_reg(3'd7, v);  check("R3", {15'd0, v < 16'd600}, 16'd1);

    // varied spacings and snapshots near the edge
    wr_reg(3'd0, 16'h0003);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk) pulse = 1'b1;
      idle(k % 5);
      wr_reg(3'd5, 16'd0);
      idle(7 + 3 * k);
      wr_reg(3'd5, 16'd0);
      rd_reg(3'd2, sb); rd_reg(3'd3, se); rd_reg(3'd4, st);
      if (evt) check("R5", st, sb - se);
      wr_reg(3'd1, 16'h0001);
      @(negedge clk) pulse = 1'b0;
      idle(5 + k);
      wr_reg(3'd5, 16'd0);
      idle(20 + 11 * k);
    end

    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule